// File: doc/BRIEF.md
# Processor-Only Reset Generator

This block drives a reset line that reaches the processor and nothing else. Memory, peripherals and the block's own retained registers keep running and keep their contents while that line is high. Software uses the line to get the processor out of protected mode and back into real mode without restarting the machine.

A pulse has one of two causes. The first is an explicit command written through a small byte-wide register port. The second is a shutdown bus cycle, which the processor issues by itself after a triple fault. A single enable bit can mask shutdown cycles. Each pulse lasts a fixed minimum length, and a trigger that arrives while a pulse is already running joins that pulse.

Two pieces of state survive a processor-only reset. One is a warm-restart flag that software sets once start-up is complete. The other is a small bank of retained bytes, and one entry of that bank holds the resume code. After the processor comes out of reset, start-up code reads both. From them it tells a warm restart apart from a power-on or button reset, and learns how to continue.

Top module: `cpu_rst_gen`

## Requirements
- R1: While `rst_ni` is low, `cpu_rst_o` is 1. The system reset also puts the registers in their reset state: warm flag 0, shutdown enable 1, and every retained byte 0x00.
- R2: After `rst_ni` rises with no trigger pending, `cpu_rst_o` falls at the first rising clock edge.
- R3: A write of 0xFE to address 0x00 raises `cpu_rst_o` at the clock edge that takes the write. The line then stays high for exactly 16 cycles. A write of any other value to address 0x00 has no effect.
- R4: A shutdown cycle is `bus_cyc_i`=1, `bus_stat_i`=3'b101 and `bus_a1_i`=0, while shutdown enable is 1. It raises `cpu_rst_o` at that edge for exactly 16 cycles.
- R5: A cycle with `bus_stat_i`=3'b101 and `bus_a1_i`=1 is a plain halt. It never raises `cpu_rst_o`. Neither does any other status code.
- R6: Address 0x01 bit 1 is the shutdown enable. While it is 0, shutdown cycles are ignored, but the write command still produces a pulse.
- R7: A trigger that arrives while `cpu_rst_o` is high joins the running pulse. It does not lengthen the pulse, and it does not start a second one.
- R8: Address 0x01 bit 0 is the warm flag. Writing 1 sets it. Writing 0 leaves it unchanged. A processor-only reset leaves it unchanged. Only `rst_ni` clears it.
- R9: Addresses 0x10 to 0x1F are 16 retained read/write bytes, and entry 15 (address 0x1F) is the shutdown-status code. Their values are unchanged by processor-only reset pulses.
- R10: Reads of address 0x00 and of addresses 0x02 to 0x0F return 0x00. Writes to 0x02 to 0x0F change nothing that can be read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | System reset, active low, asynchronous |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register address for both read and write |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Combinational read data for `reg_addr_i` |
| bus_cyc_i | input | 1 | Processor bus status is valid this cycle |
| bus_stat_i | input | 3 | Processor bus cycle type |
| bus_a1_i | input | 1 | Address bit 1 of the bus cycle |
| cpu_rst_o | output | 1 | Reset to the processor only, active high |

## Verification
The bench goes after the following corner cases, and each catches a particular bug:

- **Halt cycle with address bit 1 set:** a design that ignores A1 would reset the processor on every halt.
- **Shutdown with the enable cleared:** this exposes a mask that is never applied.
- **Triggers landing mid-pulse, and on the last high cycle:** a design that restarts its counter would stretch the pulse. A design that queues the trigger would emit a second pulse.
- **Retained state across reset pulses:** a design that wired the processor reset into its registers would lose the resume code or the warm flag. The bench reads the warm flag and the resume code during and after every pulse.
- **Zero written to the warm flag:** a design that treats the bit as plain read/write would clear the flag.
- **System reset arriving mid-pulse:** this must clear everything, and leave only the one-cycle tail after release.

// File: rtl/cpu_rst_pkg.sv
package cpu_rst_pkg;
  localparam int unsigned DATA_W      = 8;
  localparam int unsigned STAT_W      = 3;
  localparam int unsigned PULSE_DEF   = 16;
  localparam int unsigned RET_DEF     = 16;
  localparam logic [DATA_W-1:0] CMD_PULSE_DEF = 8'hFE;
  localparam logic [STAT_W-1:0] HALT_CODE_DEF = 3'b101;

  // fixed low addresses; the retained bank sits in the upper half of the map
  localparam int unsigned A_CMD  = 0;
  localparam int unsigned A_CTRL = 1;

  typedef struct packed {
    logic sd_en;
    logic warm;
  } ctrl_t;
endpackage

// File: rtl/cpu_rst_trig.sv
module cpu_rst_trig
  import cpu_rst_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter logic [DATA_W-1:0] CMD_PULSE = CMD_PULSE_DEF,
  parameter logic [STAT_W-1:0] HALT_CODE = HALT_CODE_DEF
) (
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              bus_cyc_i,
  input  logic [STAT_W-1:0] bus_stat_i,
  input  logic              bus_a1_i,
  input  logic              sd_en_i,
  output logic              trig_o
);
  logic cmd_hit;
  logic halt_cyc;
  logic sd_hit;

  always_comb begin
    cmd_hit  = we_i && (addr_i == ADDR_W'(A_CMD)) && (wdata_i == CMD_PULSE);
    halt_cyc = bus_cyc_i && (bus_stat_i == HALT_CODE);
    // A1 low marks shutdown, A1 high a plain halt
    sd_hit   = halt_cyc && !bus_a1_i && sd_en_i;
    trig_o   = cmd_hit || sd_hit;
  end
endmodule

// File: rtl/cpu_rst_stretch.sv
module cpu_rst_stretch #(
  parameter int unsigned PULSE_LEN = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic cpu_rst_o
);
  localparam int unsigned CNT_W = (PULSE_LEN > 2) ? $clog2(PULSE_LEN) : 1;

  logic             active_q;
  logic [CNT_W-1:0] cnt_q;

  // active_q resets high: the line follows the system reset and drops one edge after release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (active_q) begin
      if (cnt_q == '0) active_q <= 1'b0;
      else             cnt_q    <= cnt_q - 1'b1;
    end else if (trig_i) begin
      active_q <= 1'b1;
      cnt_q    <= CNT_W'(PULSE_LEN - 1);
    end
  end

  assign cpu_rst_o = active_q;
endmodule

// File: rtl/cpu_rst_regs.sv
module cpu_rst_regs
  import cpu_rst_pkg::*;
#(
  parameter int unsigned RET_DEPTH = 16,
  parameter int unsigned ADDR_W    = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              warm_o,
  output logic              sd_en_o
);
  localparam int unsigned IDX_W = $clog2(RET_DEPTH);

  ctrl_t            ctrl_q;
  logic [DATA_W-1:0] ret_q [RET_DEPTH];
  logic              ret_sel;
  logic              ctrl_sel;
  logic [IDX_W-1:0]  idx;

  assign ret_sel  = addr_i[ADDR_W-1];
  assign ctrl_sel = (addr_i == ADDR_W'(A_CTRL));
  assign idx      = addr_i[IDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q.warm  <= 1'b0;
      ctrl_q.sd_en <= 1'b1;
    end else if (we_i && ctrl_sel) begin
      ctrl_q.warm  <= ctrl_q.warm | wdata_i[0];
      ctrl_q.sd_en <= wdata_i[1];
    end
  end

  for (genvar i = 0; i < RET_DEPTH; i++) begin : g_ret
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    ret_q[i] <= '0;
      else if (we_i && ret_sel && idx == IDX_W'(i))   ret_q[i] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (ret_sel)       rdata_o = ret_q[idx];
    else if (ctrl_sel) rdata_o = DATA_W'(ctrl_q);
  end

  assign warm_o  = ctrl_q.warm;
  assign sd_en_o = ctrl_q.sd_en;
endmodule

// File: rtl/cpu_rst_gen.sv
module cpu_rst_gen
  import cpu_rst_pkg::*;
#(
  parameter int unsigned PULSE_LEN = PULSE_DEF,
  parameter int unsigned RET_DEPTH = RET_DEF,
  parameter logic [DATA_W-1:0] CMD_PULSE = CMD_PULSE_DEF,
  parameter logic [STAT_W-1:0] HALT_CODE = HALT_CODE_DEF,
  localparam int unsigned ADDR_W = $clog2(RET_DEPTH) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              bus_cyc_i,
  input  logic [STAT_W-1:0] bus_stat_i,
  input  logic              bus_a1_i,
  output logic              cpu_rst_o
);
  logic warm_flag;
  logic sd_en;
  logic trig;

  cpu_rst_regs #(
    .RET_DEPTH (RET_DEPTH),
    .ADDR_W    (ADDR_W)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .warm_o  (warm_flag),
    .sd_en_o (sd_en)
  );

  cpu_rst_trig #(
    .ADDR_W    (ADDR_W),
    .CMD_PULSE (CMD_PULSE),
    .HALT_CODE (HALT_CODE)
  ) u_trig (
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .bus_cyc_i  (bus_cyc_i),
    .bus_stat_i (bus_stat_i),
    .bus_a1_i   (bus_a1_i),
    .sd_en_i    (sd_en),
    .trig_o     (trig)
  );

  cpu_rst_stretch #(
    .PULSE_LEN (PULSE_LEN)
  ) u_stretch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .trig_i    (trig),
    .cpu_rst_o (cpu_rst_o)
  );
endmodule

// File: rtl/cpu_rst_gen_chk.sv
module cpu_rst_gen_chk
  import cpu_rst_pkg::*;
#(
  parameter int unsigned PULSE_LEN = 16,
  parameter int unsigned ADDR_W    = 5,
  parameter logic [DATA_W-1:0] CMD_PULSE = CMD_PULSE_DEF,
  parameter logic [STAT_W-1:0] HALT_CODE = HALT_CODE_DEF
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic              bus_cyc_i,
  input logic [STAT_W-1:0] bus_stat_i,
  input logic              bus_a1_i,
  input logic              cpu_rst_o,
  input logic              warm_flag,
  input logic              sd_en
);
  localparam int unsigned CW = $clog2(PULSE_LEN + 1);

  logic          cmd_wr;
  logic          halt_st;
  logic [CW-1:0] hi_cnt;
  logic          from_rst;

  assign cmd_wr  = reg_we_i && reg_addr_i == ADDR_W'(A_CMD) && reg_wdata_i == CMD_PULSE;
  assign halt_st = bus_cyc_i && bus_stat_i == HALT_CODE;

  // counts sampled high cycles of the current pulse, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt   <= '0;
      from_rst <= 1'b1;
    end else if (cpu_rst_o) begin
      if (hi_cnt != CW'(PULSE_LEN)) hi_cnt <= hi_cnt + 1'b1;
    end else begin
      hi_cnt   <= '0;
      from_rst <= 1'b0;
    end
  end

  AST_SYS_HOLDS: assert property (@(posedge clk_i) !rst_ni |-> cpu_rst_o); // R1
  AST_CMD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && !cpu_rst_o) |=> cpu_rst_o); // R3
  AST_SD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_st && !bus_a1_i && sd_en && !cpu_rst_o) |=> cpu_rst_o); // R4
  AST_HALT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_st && bus_a1_i && !cmd_wr && !cpu_rst_o) |=> !cpu_rst_o); // R5
  AST_SD_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sd_en && bus_cyc_i && !cmd_wr && !cpu_rst_o) |=> !cpu_rst_o); // R6
  AST_PULSE_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cpu_rst_o) |-> (from_rst || hi_cnt == CW'(PULSE_LEN))); // R3
  AST_PULSE_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_cnt == CW'(PULSE_LEN)) |-> !cpu_rst_o); // R7
  AST_WARM_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm_flag |=> warm_flag); // R8
endmodule

bind cpu_rst_gen cpu_rst_gen_chk #(
  .PULSE_LEN (PULSE_LEN),
  .ADDR_W    (ADDR_W),
  .CMD_PULSE (CMD_PULSE),
  .HALT_CODE (HALT_CODE)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .bus_cyc_i   (bus_cyc_i),
  .bus_stat_i  (bus_stat_i),
  .bus_a1_i    (bus_a1_i),
  .cpu_rst_o   (cpu_rst_o),
  .warm_flag   (warm_flag),
  .sd_en       (sd_en)
);

// File: tb/cpu_rst_gen_tb_top.sv
module cpu_rst_gen_tb_top;
  localparam int CLK_P = 10;
  localparam int PLEN  = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       we = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       bus_cyc = 1'b0;
  logic [2:0] bus_stat = '0;
  logic       bus_a1 = 1'b0;
  logic [7:0] rdata;
  logic       cpu_rst;

  int    checks = 0;
  int    fails = 0;
  bit    chk_en = 1'b0;
  bit    done = 1'b0;
  string cur_req = "R1";

  // reference model
  int          n = 0;
  int          m_end = 0;
  bit          m_tail = 1'b1;
  bit          m_warm = 1'b0;
  bit          m_sden = 1'b1;
  byte unsigned m_ret [16];

  cpu_rst_gen dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .reg_we_i    (we),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .bus_cyc_i   (bus_cyc),
    .bus_stat_i  (bus_stat),
    .bus_a1_i    (bus_a1),
    .cpu_rst_o   (cpu_rst)
  );

  always #(CLK_P/2) clk = ~clk;

  initial foreach (m_ret[i]) m_ret[i] = 8'h00;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tail = 1'b1;
      m_end  = 0;
      m_warm = 1'b0;
      m_sden = 1'b1;
      foreach (m_ret[i]) m_ret[i] = 8'h00;
    end else begin
      bit prev_hi;
      bit fire;
      n = n + 1;
      prev_hi = m_tail || ((n - 1) < m_end);
      fire = (we && addr == 5'h00 && wdata == 8'hFE) ||
             (bus_cyc && bus_stat == 3'b101 && !bus_a1 && m_sden);
      if (fire && !prev_hi) m_end = n + PLEN;
      m_tail = 1'b0;
      if (we) begin
        if (addr == 5'h01) begin
          m_warm = m_warm | wdata[0];
          m_sden = wdata[1];
        end else if (addr >= 5'h10) begin
          m_ret[addr - 5'h10] = wdata;
        end
      end
    end
  end

  function automatic logic [7:0] m_read(input logic [4:0] a);
    if (a >= 5'h10)  return m_ret[a - 5'h10];
    if (a == 5'h01)  return {6'b0, m_sden, m_warm};
    return 8'h00;
  endfunction

  always @(negedge clk) begin
    if (chk_en) begin
      logic exp_rst;
      logic [7:0] exp_rd;
      exp_rst = !rst_n || m_tail || (n < m_end);
      exp_rd  = m_read(addr);
      checks = checks + 2;
      if (cpu_rst !== exp_rst) begin
        fails++;
        $display("FAIL %s cpu_rst_o act=%0b exp=%0b t=%0t", cur_req, cpu_rst, exp_rst, $time);
      end
      if (rdata !== exp_rd) begin
        fails++;
        $display("FAIL %s rdata@%h act=%h exp=%h t=%0t", cur_req, addr, rdata, exp_rd, $time);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #(CLK_P/4);
  endtask

  task automatic idle(input int k);
    repeat (k) tick();
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    tick();
    we = 1'b0;
  endtask

  task automatic bus(input logic [2:0] st, input logic a1);
    bus_cyc = 1'b1; bus_stat = st; bus_a1 = a1;
    tick();
    bus_cyc = 1'b0; bus_a1 = 1'b0;
  endtask

  initial begin
    #1 rst_n = 1'b0;
    #1 chk_en = 1'b1;
    // R1: reset state
    cur_req = "R1"; addr = 5'h01;
    idle(3);
    addr = 5'h1F; idle(1);
    // R2: release, line drops at first edge
    cur_req = "R2"; rst_n = 1'b1;
    idle(4);
    // R8: warm flag set, zero write has no effect
    cur_req = "R8"; addr = 5'h01;
    wr(5'h01, 8'h03); idle(1);
    wr(5'h01, 8'h02); addr = 5'h01; idle(2);
    // R9: retained bytes
    cur_req = "R9";
    wr(5'h1F, 8'h0A); wr(5'h10, 8'h55); wr(5'h17, 8'hC3);
    addr = 5'h1F; idle(2);
    // R3: non-command value, then the command
    cur_req = "R3";
    wr(5'h00, 8'h12); idle(3);
    wr(5'h00, 8'hFE); addr = 5'h1F; idle(10);
    cur_req = "R9"; addr = 5'h17; idle(4);
    cur_req = "R8"; addr = 5'h01; idle(6);
    // R4: shutdown cycle
    cur_req = "R4";
    bus(3'b101, 1'b0); addr = 5'h1F; idle(20);
    // R5: plain halt and other codes
    cur_req = "R5";
    bus(3'b101, 1'b1); idle(2);
    bus(3'b100, 1'b0); bus(3'b001, 1'b0); idle(4);
    // R7: triggers mid-pulse and on last high cycle
    cur_req = "R7";
    wr(5'h00, 8'hFE); idle(4);
    bus(3'b101, 1'b0); idle(9);
    wr(5'h00, 8'hFE); idle(4);
    wr(5'h00, 8'hFE);
    idle(PLEN - 2);
    bus(3'b101, 1'b0);
    idle(20);
    // R6: shutdown masked, command still works
    cur_req = "R6";
    wr(5'h01, 8'h00); addr = 5'h01; idle(1);
    bus(3'b101, 1'b0); idle(5);
    wr(5'h00, 8'hFE); idle(20);
    wr(5'h01, 8'h02); idle(2);
    // R10: unmapped and command addresses read zero
    cur_req = "R10";
    wr(5'h05, 8'h77); addr = 5'h05; idle(2);
    addr = 5'h00; idle(1);
    addr = 5'h0F; idle(1);
    // R1: system reset during a pulse clears everything
    cur_req = "R1";
    wr(5'h00, 8'hFE); addr = 5'h01; idle(4);
    rst_n = 1'b0; idle(3);
    addr = 5'h1F; idle(1);
    cur_req = "R2"; rst_n = 1'b1; idle(4);
    cur_req = "R9"; addr = 5'h10; idle(2);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule